// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous static memory with a shared data path. Every synchronous control and data input is captured on a rising clock edge into an input register. The registered request is then carried out on the next edge. A read loads the addressed word into an output register, so read data reaches the pins one pipeline stage after the request was captured. The data bus is modelled as a separate write-data input and read-data output, together with a flag that shows when the output would be driving the bus.

Each word is split into nine-bit lanes. Each lane can be written on its own through an active-low lane select, while a global write strobe writes every lane at once. Three chip selects of mixed polarity must all be active for a cycle to do anything. The output enable acts without waiting for a clock. A read that comes straight after an idle cycle keeps its output quiet for that first clock, so that several banks can share one bus without contention. The depth is a parameter.

Top module: `psram_top`

## Requirements
- R1: A read presented before rising edge k drives its word on `rdata` with `rvalid` high after edge k+1. Between edge k and edge k+1 the output still shows the result of the request before it.
- R2: Lane i occupies bits 9*i+8 down to 9*i. With `bwe_n` low and `gw_n` high, lane i is written exactly when `bsel_n[i]` is low, and every other lane keeps its old content.
- R3: With `gw_n` low, all lanes are written whatever `bwe_n` and `bsel_n` hold.
- R4: A cycle with `bwe_n` low, `gw_n` high and all `bsel_n` bits high is a write cycle that changes no lane.
- R5: The block is selected only when `cs1_n` is 0, `cs2` is 1 and `cs3_n` is 0. A deselected cycle writes nothing and reads nothing.
- R6: In the output stage that follows a write cycle or a deselected cycle, `rvalid` is 0 and `rdata` is all zeros. Whenever `rvalid` is 0, `rdata` is 0.
- R7: Taking `oe_n` high forces `rvalid` and `rdata` to 0 at once, with no clock edge. Taking it low again restores a pending valid read.
- R8: The output stage of a read whose previous request was a deselected cycle, or which is the first request after reset, keeps `rvalid` at 0 even with `oe_n` low.
- R9: A read issued on the cycle straight after a write to the same address returns the newly written word.
- R10: While `rst_n` is low and after it is released, `rvalid` and `rdata` are 0 until a valid read reaches the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr | input | AW (8) | Word address |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| bsel_n | input | LANES (4) | Per-lane write selects, active low, bit i for lane i |
| wdata | input | WW (36) | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | WW (36) | Read data, zero when not driven |
| rvalid | output | 1 | Output is driving the bus |

## Verification
The bench writes a known full word and then overwrites selected lanes with all ones, using lane patterns such as 1110 and 0101. A decode that numbers the lanes in reverse, or that ignores the selects, returns a different word. It sets `gw_n` low with every lane select high, and it sets `bwe_n` low with every lane select high. These cases catch a global strobe that loses to the lane selects and an empty mask that still writes. It clears each chip select in turn, both on a read and on a write, and then reads the word back. This exposes a wrong polarity or a write that slips through while deselected. It also checks the masked first read after an idle cycle and after reset, the read-after-write return, the timing of the output register, and an `oe_n` toggle between edges, which a registered enable would miss.

// File: rtl/psram_pkg.sv
package psram_pkg;

   localparam int DEF_LANE_W = 9;
   localparam int DEF_LANES  = 4;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

endpackage

// File: rtl/psram_in_stage.sv
module psram_in_stage
   import psram_pkg::*;
#(
   parameter int AW     = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int WW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             cs1_n,
   input  logic             cs2,
   input  logic             cs3_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   input  logic [WW-1:0]    wdata,
   output op_e              s1_op,
   output logic [AW-1:0]    s1_addr,
   output logic [WW-1:0]    s1_wdata,
   output logic             s1_gw_n,
   output logic [LANES-1:0] s1_bsel_n,
   output logic             s1_prev_idle
);

   logic selected;
   op_e  op_d;

   always_comb begin
      selected = !cs1_n && cs2 && !cs3_n;
      if (!selected)
         op_d = OP_IDLE;
      else if (!gw_n || !bwe_n)
         op_d = OP_WRITE;
      else
         op_d = OP_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op        <= OP_IDLE;
         s1_addr      <= '0;
         s1_wdata     <= '0;
         s1_gw_n      <= 1'b1;
         s1_bsel_n    <= '1;
         s1_prev_idle <= 1'b1;
      end else begin
         s1_op        <= op_d;
         s1_addr      <= addr;
         s1_wdata     <= wdata;
         s1_gw_n      <= gw_n;
         s1_bsel_n    <= bsel_n;
         s1_prev_idle <= (s1_op == OP_IDLE);
      end
   end

   AST_DESEL_GIVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs1_n || !cs2 || cs3_n) |=> (s1_op == OP_IDLE)); // R5

endmodule

// File: rtl/psram_wr_decode.sv
module psram_wr_decode
   import psram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  op_e              op,
   input  logic             gw_n,
   input  logic [LANES-1:0] bsel_n,
   output logic [LANES-1:0] lane_we
);

   logic is_write;
   assign is_write = (op == OP_WRITE);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_we[i] = is_write && (!gw_n || !bsel_n[i]);
   end

endmodule

// File: rtl/psram_mem.sv
module psram_mem #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int WW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] lane_we,
   input  logic [WW-1:0]    wdata,
   output logic [WW-1:0]    rd_word
);

   for (genvar i = 0; i < LANES; i++) begin : g_bank
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[i])
            cells[addr] <= wdata[i*LANE_W +: LANE_W];
      end

      assign rd_word[i*LANE_W +: LANE_W] = cells[addr];
   end

endmodule

// File: rtl/psram_out_stage.sv
module psram_out_stage
   import psram_pkg::*;
#(
   parameter int WW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  op_e           s1_op,
   input  logic          s1_prev_idle,
   input  logic [WW-1:0] rd_word,
   input  logic          oe_n,
   output logic [WW-1:0] rdata,
   output logic          rvalid
);

   logic          out_act;
   logic          out_mask;
   logic [WW-1:0] dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_act  <= 1'b0;
         out_mask <= 1'b0;
         dout_q   <= '0;
      end else begin
         out_act  <= (s1_op == OP_READ);
         out_mask <= (s1_op == OP_READ) && s1_prev_idle;
         if (s1_op == OP_READ)
            dout_q <= rd_word;
      end
   end

   assign rvalid = out_act && !out_mask && !oe_n;
   assign rdata  = rvalid ? dout_q : '0;

   AST_QUIET_AFTER_NONREAD: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_op != OP_READ) |=> !out_act); // R6
   AST_FIRST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_op == OP_READ && s1_prev_idle) |=> !rvalid); // R8
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_op == OP_READ && !s1_prev_idle) |=> (rvalid || oe_n)); // R1

endmodule

// File: rtl/psram_top.sv
module psram_top
   import psram_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter int LANES  = DEF_LANES,
   parameter int LANE_W = DEF_LANE_W,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int WW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             cs1_n,
   input  logic             cs2,
   input  logic             cs3_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   input  logic [WW-1:0]    wdata,
   input  logic             oe_n,
   output logic [WW-1:0]    rdata,
   output logic             rvalid
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("psram_top: DEPTH must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("psram_top: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("psram_top: LANE_W must be at least 1");
   end

   op_e              s1_op;
   logic [AW-1:0]    s1_addr;
   logic [WW-1:0]    s1_wdata;
   logic             s1_gw_n;
   logic [LANES-1:0] s1_bsel_n;
   logic             s1_prev_idle;
   logic [LANES-1:0] lane_we;
   logic [WW-1:0]    rd_word;

   psram_in_stage #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_in (
      .clk, .rst_n, .addr, .cs1_n, .cs2, .cs3_n, .gw_n, .bwe_n, .bsel_n, .wdata,
      .s1_op, .s1_addr, .s1_wdata, .s1_gw_n, .s1_bsel_n, .s1_prev_idle
   );

   psram_wr_decode #(.LANES(LANES)) u_dec (
      .op(s1_op), .gw_n(s1_gw_n), .bsel_n(s1_bsel_n), .lane_we
   );

   psram_mem #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk, .addr(s1_addr), .lane_we, .wdata(s1_wdata), .rd_word
   );

   psram_out_stage #(.WW(WW)) u_out (
      .clk, .rst_n, .s1_op, .s1_prev_idle, .rd_word, .oe_n, .rdata, .rvalid
   );

   AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(lane_we) != 0) |-> $past(!cs1_n && cs2 && !cs3_n)); // R5
   AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_op == OP_WRITE && !s1_gw_n) |-> (lane_we == '1)); // R3
   AST_EMPTY_MASK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_gw_n && s1_bsel_n == '1) |-> (lane_we == '0)); // R4

endmodule

// File: tb/psram_top_tb_top.sv
module psram_top_tb_top;

   localparam int CLK_P = 10;
   localparam logic [35:0] D1 = 36'h1_2345_6789;

   typedef struct packed {
      logic [2:0]  cs;     // {cs1_n, cs2, cs3_n}
      logic        gw_n;
      logic        bwe_n;
      logic [3:0]  bsel_n;
      logic [7:0]  addr;
      logic [35:0] wd;
      logic        ev;
      logic [35:0] ed;
   } vec_t;

   localparam vec_t IDLE_V = '{3'b110, 1'b1, 1'b1, 4'hF, 8'd0, 36'h0, 1'b0, 36'h0};
   localparam int NV = 23;
   localparam vec_t VT [NV] = '{
      '{3'b110, 1'b1, 1'b1, 4'hF, 8'd0, 36'h0,          1'b0, 36'h0},           // R5 deselected read
      '{3'b010, 1'b0, 1'b1, 4'hF, 8'd1, D1,             1'b0, 36'h0},           // R6 global write
      '{3'b010, 1'b0, 1'b1, 4'hF, 8'd2, 36'h0,          1'b0, 36'h0},
      '{3'b010, 1'b1, 1'b0, 4'hE, 8'd2, 36'hF_FFFF_FFFF, 1'b0, 36'h0},          // R2 lane 0 only
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd1, 36'h0,          1'b1, D1},              // R1 read after write
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd2, 36'h0,          1'b1, 36'h0_0000_01FF}, // R2
      '{3'b010, 1'b0, 1'b1, 4'hF, 8'd2, 36'hA_BCDE_F012, 1'b0, 36'h0},          // R3 gw over selects
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd2, 36'h0,          1'b1, 36'hA_BCDE_F012}, // R3 R9
      '{3'b010, 1'b1, 1'b0, 4'hF, 8'd1, 36'h0,          1'b0, 36'h0},           // R4 empty mask
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd1, 36'h0,          1'b1, D1},              // R4
      '{3'b010, 1'b1, 1'b0, 4'h5, 8'd1, 36'hF_FFFF_FFFF, 1'b0, 36'h0},          // R2 lanes 1 and 3
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd1, 36'h0,          1'b1, 36'hF_FB47_FF89}, // R2 R9
      '{3'b110, 1'b1, 1'b1, 4'hF, 8'd0, 36'h0,          1'b0, 36'h0},           // R6 deselect
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd2, 36'h0,          1'b0, 36'h0},           // R8 masked
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd2, 36'h0,          1'b1, 36'hA_BCDE_F012}, // R8
      '{3'b000, 1'b1, 1'b1, 4'hF, 8'd2, 36'h0,          1'b0, 36'h0},           // R5 cs2 low
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd1, 36'h0,          1'b0, 36'h0},           // R8
      '{3'b011, 1'b0, 1'b1, 4'hF, 8'd1, 36'h0,          1'b0, 36'h0},           // R5 cs3_n high write
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd1, 36'h0,          1'b0, 36'h0},           // R8
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd1, 36'h0,          1'b1, 36'hF_FB47_FF89}, // R5 not written
      '{3'b110, 1'b0, 1'b1, 4'hF, 8'd2, 36'h0,          1'b0, 36'h0},           // R5 cs1_n high write
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd2, 36'h0,          1'b0, 36'h0},           // R8
      '{3'b010, 1'b1, 1'b1, 4'hF, 8'd2, 36'h0,          1'b1, 36'hA_BCDE_F012}  // R5 not written
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr;
   logic        cs1_n, cs2, cs3_n, gw_n, bwe_n, oe_n;
   logic [3:0]  bsel_n;
   logic [35:0] wdata;
   logic [35:0] rdata;
   logic        rvalid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   psram_top dut_i (
      .clk, .rst_n, .addr, .cs1_n, .cs2, .cs3_n, .gw_n, .bwe_n, .bsel_n,
      .wdata, .oe_n, .rdata, .rvalid
   );

   task automatic drive(input vec_t v);
      {cs1_n, cs2, cs3_n} = v.cs;
      gw_n   = v.gw_n;
      bwe_n  = v.bwe_n;
      bsel_n = v.bsel_n;
      addr   = v.addr;
      wdata  = v.wd;
   endtask

   task automatic check(input string tag, input logic ev, input logic [35:0] ed);
      n_chk++;
      if (rvalid !== ev || rdata !== ed) begin
         n_bad++;
         $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                  tag, rvalid, rdata, ev, ed);
      end
   endtask

   initial begin
      drive(IDLE_V);
      oe_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R10 in reset", 1'b0, 36'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after release", 1'b0, 36'h0);

      // table walk: each vector is checked two falling edges after it is driven
      for (int i = 0; i < NV + 2; i++) begin
         @(negedge clk);
         if (i >= 2)
            check($sformatf("vector %0d", i - 2), VT[i-2].ev, VT[i-2].ed);
         drive(i < NV ? VT[i] : IDLE_V);
      end

      // R1 latency and R7 asynchronous output enable
      drive('{3'b010, 1'b1, 1'b1, 4'hF, 8'd2, 36'h0, 1'b0, 36'h0});
      @(negedge clk);
      @(negedge clk);
      drive('{3'b010, 1'b1, 1'b1, 4'hF, 8'd1, 36'h0, 1'b0, 36'h0});
      @(negedge clk);
      check("R1 previous word still shown", 1'b1, 36'hA_BCDE_F012);
      drive(IDLE_V);
      #1 oe_n = 1'b1;
      #1 check("R7 oe_n high", 1'b0, 36'h0);
      oe_n = 1'b0;
      #1 check("R7 oe_n low again", 1'b1, 36'hA_BCDE_F012);
      @(negedge clk);
      check("R1 new word after second edge", 1'b1, 36'hF_FB47_FF89);
      @(negedge clk);
      check("R6 idle output", 1'b0, 36'h0);

      // R10 and R8: reset mid-stream, first read afterwards masked
      drive('{3'b010, 1'b1, 1'b1, 4'hF, 8'd1, 36'h0, 1'b0, 36'h0});
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1 check("R10 reset clears output", 1'b0, 36'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R8 first read after reset masked", 1'b0, 36'h0);
      @(negedge clk);
      check("R8 second read after reset", 1'b1, 36'hF_FB47_FF89);
      drive(IDLE_V);
      @(negedge clk);
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 2000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule